// File: doc/BRIEF.md
# Pipelined Hybrid Parallel-Prefix Adder

This block adds two unsigned WIDTH-bit operands and a carry-in, and produces a WIDTH-bit sum and a carry-out. The carries come from a parallel-prefix network built in three parts. A sparse upward sweep first forms group generate/propagate terms over aligned blocks of 2^BK_LEVELS bits. A dense all-pairs network then resolves the full prefix at every block top. A sparse downward sweep finally fills in the positions inside each block. Before the network, the carry-in is merged into bit 0 as an extra generate term. After the network, each sum bit is the bit's own propagate XOR the prefix generate of all bits below it.

In pipelined mode, registers sit at the seams of this structure: after the generate/propagate precompute, after the upward sweep, after the dense network, and after the downward sweep with the sum postcompute. The adder takes a new operand pair on every clock and returns each result exactly four clocks later, tagged by a valid bit. A parameter removes all four registers and gives a purely combinational adder with the same ports, for use where latency matters more than clock rate.

Top module: `hybrid_prefix_adder`

## Requirements
- R1: When a result is presented with out_valid high, {cout, sum} equals x + y + cin of the matching operation, taken as a (WIDTH+1)-bit unsigned value.
- R2: cin carries a weight of one at bit 0. With x = y = 0 and cin = 1 the sum is 1. With x all ones, y = 0 and cin = 1 the sum is 0 and cout is 1.
- R3: A carry that enters at bit 0 reaches cout across the full width. With x all ones, y = 1 and cin = 0 the sum is 0 and cout is 1. When every bit propagates, cout equals cin.
- R4: With PIPELINED = 1, out_valid equals in_valid from four rising edges earlier. The sum and cout shown alongside belong to that operation, and operations with in_valid low produce no valid result.
- R5: With PIPELINED = 1, operations presented on consecutive clocks each produce a correct result, in issue order, on consecutive clocks.
- R6: A synchronous reset (rst high at a rising edge) drops out_valid and discards every operation in flight. After reset, out_valid stays low until a newly issued operation has had time to come out.
- R7: With PIPELINED = 0, the block has no registers. out_valid equals in_valid and sum/cout follow x, y and cin within the same cycle.
- R8: The block works for any WIDTH of at least 2 that is a multiple of 2^BK_LEVELS. This includes settings where the number of blocks is not a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears valid bits only |
| in_valid | input | 1 | Marks x, y and cin as an operation to perform |
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Marks sum and cout as a result |
| sum | output | WIDTH | Low WIDTH bits of x + y + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench builds three instances. The first uses the default 256-bit width with two sparse levels; it carries the long-carry, streaming, bubble and reset-flush cases at full size. The second is a pipelined 24-bit adder with three sparse levels. It has only three block tops, so the dense network runs over a count that is not a power of two and uses its edge conditions. The third is a combinational 8-bit adder with one sparse level, small enough that every combination of operands and carry-in is checked.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

    // Merge a higher group with the adjacent lower group: returns {g, p}.
    function automatic logic [1:0] gp_merge(
        input logic g_hi,
        input logic p_hi,
        input logic g_lo,
        input logic p_lo
    );
        return {g_hi | (p_hi & g_lo), p_hi & p_lo};
    endfunction

endpackage

// File: rtl/hpa_pre.sv
module hpa_pre #(
    parameter int WIDTH = 256
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);

    // Bitwise generate/propagate; the carry-in joins bit 0 as extra generate.
    always_comb begin
        p_o    = x ^ y;
        g_o    = x & y;
        g_o[0] = g_o[0] | (p_o[0] & cin);
    end

endmodule

// File: rtl/hpa_bk_sweep.sv
module hpa_bk_sweep
    import hpa_pkg::*;
#(
    parameter int WIDTH  = 256,
    parameter int LEVELS = 2,
    parameter bit UPWARD = 1'b1
) (
    input  logic [WIDTH-1:0] g_i,
    input  logic [WIDTH-1:0] p_i,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);

    if (UPWARD) begin : g_upsweep
        logic [WIDTH-1:0] g_cur, p_cur, g_nxt, p_nxt;
        // Level lv builds spans of 2^(lv+1) at positions aligned to that span.
        always_comb begin
            g_cur = g_i;
            p_cur = p_i;
            g_nxt = g_i;
            p_nxt = p_i;
            for (int lv = 0; lv < LEVELS; lv++) begin
                g_nxt = g_cur;
                p_nxt = p_cur;
                for (int b = 0; b < WIDTH; b++) begin
                    if (((b + 1) % (2 << lv)) == 0) begin
                        {g_nxt[b], p_nxt[b]} = gp_merge(g_cur[b], p_cur[b],
                                                        g_cur[b - (1 << lv)],
                                                        p_cur[b - (1 << lv)]);
                    end
                end
                g_cur = g_nxt;
                p_cur = p_nxt;
            end
            g_o = g_cur;
            p_o = p_cur;
        end
    end else begin : g_downsweep
        logic [WIDTH-1:0] g_cur, p_cur, g_nxt, p_nxt;
        // Widest span first: a position holding a partial span of 2^d joins
        // the finished prefix directly below it.
        always_comb begin
            g_cur = g_i;
            p_cur = p_i;
            g_nxt = g_i;
            p_nxt = p_i;
            for (int k = 0; k < LEVELS; k++) begin
                g_nxt = g_cur;
                p_nxt = p_cur;
                for (int b = 0; b < WIDTH; b++) begin
                    if ((((b + 1) % (1 << (LEVELS - 1 - k))) == 0) &&
                        (((b + 1) % (2 << (LEVELS - 1 - k))) != 0) &&
                        (b >= (1 << (LEVELS - 1 - k)))) begin
                        {g_nxt[b], p_nxt[b]} = gp_merge(g_cur[b], p_cur[b],
                                                        g_cur[b - (1 << (LEVELS - 1 - k))],
                                                        p_cur[b - (1 << (LEVELS - 1 - k))]);
                    end
                end
                g_cur = g_nxt;
                p_cur = p_nxt;
            end
            g_o = g_cur;
            p_o = p_cur;
        end
    end

endmodule

// File: rtl/hpa_ks.sv
module hpa_ks
    import hpa_pkg::*;
#(
    parameter int WIDTH  = 256,
    parameter int STRIDE = 4
) (
    input  logic [WIDTH-1:0] g_i,
    input  logic [WIDTH-1:0] p_i,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);

    localparam int TOPS  = WIDTH / STRIDE;
    localparam int RANKS = (TOPS > 1) ? $clog2(TOPS) : 0;

    logic [WIDTH-1:0] g_cur, p_cur, g_nxt, p_nxt;

    // Dense network over the block tops only: every top merges each rank.
    always_comb begin
        int hi;
        int lo;
        hi    = 0;
        lo    = 0;
        g_cur = g_i;
        p_cur = p_i;
        g_nxt = g_i;
        p_nxt = p_i;
        for (int r = 0; r < RANKS; r++) begin
            g_nxt = g_cur;
            p_nxt = p_cur;
            for (int t = 0; t < TOPS; t++) begin
                if (t >= (1 << r)) begin
                    hi = (t + 1) * STRIDE - 1;
                    lo = hi - (STRIDE << r);
                    {g_nxt[hi], p_nxt[hi]} = gp_merge(g_cur[hi], p_cur[hi],
                                                      g_cur[lo], p_cur[lo]);
                end
            end
            g_cur = g_nxt;
            p_cur = p_nxt;
        end
        g_o = g_cur;
        p_o = p_cur;
    end

endmodule

// File: rtl/hpa_stage.sv
module hpa_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld_i,
    input  logic [DW-1:0] dat_i,
    output logic          vld_o,
    output logic [DW-1:0] dat_o
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d.vld = vld_i;
        slot_d.dat = dat_i;
    end

    // Only the valid bit is reset; data follows its valid bit.
    always_ff @(posedge clk) begin
        if (rst) slot_q.vld <= 1'b0;
        else     slot_q.vld <= slot_d.vld;
        slot_q.dat <= slot_d.dat;
    end

    assign vld_o = slot_q.vld;
    assign dat_o = slot_q.dat;

    assert_valid_reset_R6: assert property (@(posedge clk) rst |=> !vld_o)
        else $error("stage valid survived reset");

    assert_valid_follow_R4: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o)
        else $error("stage lost a valid operation");

    assert_valid_drop_R4: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o)
        else $error("stage invented a valid operation");

endmodule

// File: rtl/hybrid_prefix_adder.sv
module hybrid_prefix_adder
    import hpa_pkg::*;
#(
    parameter int WIDTH     = 256,
    parameter int BK_LEVELS = 2,
    parameter bit PIPELINED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int GROUP = 1 << BK_LEVELS;

    typedef struct packed {
        logic             cin;
        logic [WIDTH-1:0] porig;
        logic [WIDTH-1:0] p;
        logic [WIDTH-1:0] g;
    } lane_t;

    typedef struct packed {
        logic             carry;
        logic [WIDTH-1:0] total;
    } result_t;

    lane_t   pre_d, s1_q, up_d, s2_q, ks_d, s3_q;
    result_t post_d, s4_q;
    logic    s1_vld, s2_vld, s3_vld;

    logic [WIDTH-1:0] g_pre, p_pre, g_up, p_up, g_ks, p_ks, g_dn, p_dn;
    logic [WIDTH:0]   carry_vec;

    // Precompute.
    hpa_pre #(.WIDTH(WIDTH)) u_pre (
        .x   (x),
        .y   (y),
        .cin (cin),
        .g_o (g_pre),
        .p_o (p_pre)
    );

    always_comb begin
        pre_d.cin   = cin;
        pre_d.porig = p_pre;
        pre_d.p     = p_pre;
        pre_d.g     = g_pre;
    end

    // Sparse upward sweep.
    hpa_bk_sweep #(.WIDTH(WIDTH), .LEVELS(BK_LEVELS), .UPWARD(1'b1)) u_up (
        .g_i (s1_q.g),
        .p_i (s1_q.p),
        .g_o (g_up),
        .p_o (p_up)
    );

    always_comb begin
        up_d   = s1_q;
        up_d.g = g_up;
        up_d.p = p_up;
    end

    // Dense network across block tops.
    hpa_ks #(.WIDTH(WIDTH), .STRIDE(GROUP)) u_ks (
        .g_i (s2_q.g),
        .p_i (s2_q.p),
        .g_o (g_ks),
        .p_o (p_ks)
    );

    always_comb begin
        ks_d   = s2_q;
        ks_d.g = g_ks;
        ks_d.p = p_ks;
    end

    // Sparse downward sweep and sum postcompute.
    hpa_bk_sweep #(.WIDTH(WIDTH), .LEVELS(BK_LEVELS), .UPWARD(1'b0)) u_down (
        .g_i (s3_q.g),
        .p_i (s3_q.p),
        .g_o (g_dn),
        .p_o (p_dn)
    );

    always_comb begin
        carry_vec    = {g_dn, s3_q.cin};
        post_d.total = s3_q.porig ^ carry_vec[WIDTH-1:0];
        post_d.carry = carry_vec[WIDTH];
    end

    if (PIPELINED) begin : g_pipe
        hpa_stage #(.DW($bits(lane_t))) u_s1 (
            .clk (clk), .rst (rst),
            .vld_i (in_valid), .dat_i (pre_d),
            .vld_o (s1_vld),   .dat_o (s1_q)
        );
        hpa_stage #(.DW($bits(lane_t))) u_s2 (
            .clk (clk), .rst (rst),
            .vld_i (s1_vld), .dat_i (up_d),
            .vld_o (s2_vld), .dat_o (s2_q)
        );
        hpa_stage #(.DW($bits(lane_t))) u_s3 (
            .clk (clk), .rst (rst),
            .vld_i (s2_vld), .dat_i (ks_d),
            .vld_o (s3_vld), .dat_o (s3_q)
        );
        hpa_stage #(.DW($bits(result_t))) u_s4 (
            .clk (clk), .rst (rst),
            .vld_i (s3_vld),    .dat_i (post_d),
            .vld_o (out_valid), .dat_o (s4_q)
        );
    end else begin : g_flat
        assign s1_vld    = in_valid;
        assign s1_q      = pre_d;
        assign s2_vld    = s1_vld;
        assign s2_q      = up_d;
        assign s3_vld    = s2_vld;
        assign s3_q      = ks_d;
        assign out_valid = s3_vld;
        assign s4_q      = post_d;

        // Prefix network against a plain wide addition, same cycle.
        assert_sum_R7: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> ({cout, sum} ==
                          ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin})))
            else $error("combinational sum mismatch");
    end

    assign sum  = s4_q.total;
    assign cout = s4_q.carry;

    // Above bit 0 a bit cannot both generate and propagate.
    assert_gp_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> ((s1_q.g[WIDTH-1:1] & s1_q.p[WIDTH-1:1]) == '0))
        else $error("generate and propagate overlap");

    // A finished prefix propagate implies the bit itself propagates.
    assert_prefix_p_R3: assert property (@(posedge clk) disable iff (rst)
        s3_vld |-> ((p_dn & ~s3_q.porig) == '0))
        else $error("prefix propagate without bit propagate");

    // Full-width propagate passes the carry-in straight to the carry-out.
    assert_full_propagate_R3: assert property (@(posedge clk) disable iff (rst)
        (s3_vld && p_dn[WIDTH-1]) |-> (g_dn[WIDTH-1] == s3_q.cin))
        else $error("carry-in lost on full propagate");

endmodule

// File: tb/hybrid_prefix_adder_tb.sv
module hybrid_prefix_adder_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [255:0] x = '0;
    logic [255:0] y = '0;
    logic         cin = 1'b0;
    logic         out_valid;
    logic [255:0] sum;
    logic         cout;

    logic         o_valid;
    logic [23:0]  o_sum;
    logic         o_cout;

    logic         c_valid = 1'b0;
    logic [7:0]   cx = '0;
    logic [7:0]   cy = '0;
    logic         ccin = 1'b0;
    logic         cq_valid;
    logic [7:0]   cq_sum;
    logic         cq_cout;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [255:0] vx [64];
    logic [255:0] vy [64];
    logic         vc [64];
    logic         vv [64];
    int           nvec = 0;

    always #10 clk = ~clk;

    hybrid_prefix_adder #(.WIDTH(256), .BK_LEVELS(2), .PIPELINED(1'b1)) u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .x (x), .y (y), .cin (cin),
        .out_valid (out_valid), .sum (sum), .cout (cout)
    );

    hybrid_prefix_adder #(.WIDTH(24), .BK_LEVELS(3), .PIPELINED(1'b1)) u_odd (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .x (x[23:0]), .y (y[23:0]), .cin (cin),
        .out_valid (o_valid), .sum (o_sum), .cout (o_cout)
    );

    hybrid_prefix_adder #(.WIDTH(8), .BK_LEVELS(1), .PIPELINED(1'b0)) u_comb (
        .clk (clk), .rst (rst), .in_valid (c_valid),
        .x (cx), .y (cy), .cin (ccin),
        .out_valid (cq_valid), .sum (cq_sum), .cout (cq_cout)
    );

    task automatic check(string req, string what, logic [256:0] act, logic [256:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [256:0] ref_wide(logic [255:0] a, logic [255:0] b, logic ci);
        return {1'b0, a} + {1'b0, b} + {256'b0, ci};
    endfunction

    function automatic logic [256:0] ref_odd(logic [255:0] a, logic [255:0] b, logic ci);
        logic [24:0] r;
        r = {1'b0, a[23:0]} + {1'b0, b[23:0]} + {24'b0, ci};
        return {232'b0, r};
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic push(logic v, logic [255:0] a, logic [255:0] b, logic ci);
        vv[nvec] = v;
        vx[nvec] = a;
        vy[nvec] = b;
        vc[nvec] = ci;
        nvec++;
    endtask

    // Issue queued vectors one per cycle; each result is due four negedges later.
    task automatic run_queue(string req);
        for (int c = 0; c < nvec + 4; c++) begin
            @(negedge clk);
            if (c >= 4) begin
                int k;
                k = c - 4;
                check("R4", "out_valid", {256'b0, out_valid}, {256'b0, vv[k]});
                check("R8", "odd out_valid", {256'b0, o_valid}, {256'b0, vv[k]});
                if (vv[k]) begin
                    check(req, "cout,sum", {cout, sum}, ref_wide(vx[k], vy[k], vc[k]));
                    check("R8", "odd cout,sum", {232'b0, o_cout, o_sum},
                          ref_odd(vx[k], vy[k], vc[k]));
                end
            end
            if (c < nvec) begin
                in_valid = vv[c];
                x        = vx[c];
                y        = vy[c];
                cin      = vc[c];
            end else begin
                in_valid = 1'b0;
            end
        end
        nvec = 0;
    endtask

    task automatic test_reset_state();
        repeat (3) @(negedge clk);
        check("R6", "out_valid in reset", {256'b0, out_valid}, '0);
        check("R6", "odd out_valid in reset", {256'b0, o_valid}, '0);
        rst = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check("R6", "out_valid after reset", {256'b0, out_valid}, '0);
        end
    endtask

    task automatic test_carry_in();
        push(1'b1, '0, '0, 1'b1);
        push(1'b1, '1, '0, 1'b1);
        push(1'b1, '0, '0, 1'b0);
        push(1'b1, 256'd5, 256'd7, 1'b1);
        push(1'b1, '1, '1, 1'b1);
        run_queue("R2");
    endtask

    task automatic test_full_ripple();
        push(1'b1, '1, 256'd1, 1'b0);
        push(1'b1, {128{2'b10}}, {128{2'b01}}, 1'b1);
        push(1'b1, 256'd1 << 255, 256'd1 << 255, 1'b0);
        push(1'b1, {128{2'b10}}, {128{2'b01}}, 1'b0);
        push(1'b1, {255'b0, 1'b1} << 24, '1, 1'b0);
        run_queue("R3");
    endtask

    task automatic test_stream();
        for (int i = 0; i < 48; i++) push(1'b1, rnd256(), rnd256(), 1'($urandom));
        run_queue("R5");
    endtask

    task automatic test_bubbles();
        for (int i = 0; i < 24; i++)
            push(((i % 3) != 1) && (i != 7), rnd256(), rnd256(), 1'($urandom));
        run_queue("R4");
    endtask

    task automatic test_flush();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            x        = rnd256();
            y        = rnd256();
            cin      = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            check("R6", "out_valid after flush", {256'b0, out_valid}, '0);
            check("R6", "odd out_valid after flush", {256'b0, o_valid}, '0);
            @(negedge clk);
        end
        push(1'b1, 256'd3, 256'd4, 1'b0);
        run_queue("R6");
    endtask

    task automatic test_comb();
        @(negedge clk);
        c_valid = 1'b0;
        #1;
        check("R7", "comb out_valid low", {256'b0, cq_valid}, '0);
        c_valid = 1'b1;
        #1;
        check("R7", "comb out_valid high", {256'b0, cq_valid}, 257'd1);
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    cx   = 8'(a);
                    cy   = 8'(b);
                    ccin = 1'(ci);
                    #1;
                    check("R7", "comb cout,sum", {248'b0, cq_cout, cq_sum},
                          257'(a + b + ci));
                end
            end
        end
        c_valid = 1'b0;
    endtask

    initial begin
        test_reset_state();
        test_carry_in();
        test_full_ripple();
        test_stream();
        test_bubbles();
        test_flush();
        test_comb();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R5 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule